// File: doc/BRIEF.md
# Double-Buffered Block Load Responder

This block is the receiving end of a block-load handshake. A host streams the words of a block into one of two banks. It then pulses a load request. While the block in one bank is being read out to a pixel array, the host may already fill the other bank. The responder holds the active-low `busy_n` pin low for each load operation. The rising edge of `busy_n` tells the host that a load has finished and that its bank is free again.

A request may arrive while a load is still running. The responder keeps one such request and starts it on the cycle after the running load ends. A request that would need a second waiting slot is discarded and recorded in a sticky flag. Command-only requests (clear or set) give the same `busy_n` low/high pattern. They last a shorter, separately parameterised time, read no bank and do not advance the read bank. If the host writes into a bank whose block has not yet finished loading, the data is corrupted, and the responder raises a sticky overrun flag.

Input back-pressure: a word moves when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` drops once DEPTH words of the current block have been accepted. It rises again after the next data request commits that block. A word presented while `in_ready` is low stays with the host. The output stream has no ready input, because the array takes one word per cycle without stalling.

Top module: `blkld_responder`

## Requirements
- R1: After reset, `busy_n`=1, `in_ready`=1, `out_valid`=0, `overrun`=0 and `req_lost`=0.
- R2: `in_ready` is high while fewer than DEPTH words have been accepted since the last data request. It is low after DEPTH words and returns high the cycle after a data request. Words offered while it is low are not stored.
- R3: A data request (`load_cmd`=0) sampled while idle drives `busy_n` low from the next cycle for exactly LOAD_CYCLES cycles, after which it returns high.
- R4: During the first DEPTH cycles of a data load, `out_valid` is high and `out_data` gives the committed block's words in write order, one per cycle with no back-pressure. `out_valid` is never high while `busy_n` is high.
- R5: A command request (`load_cmd`=1) holds `busy_n` low for exactly CMD_CYCLES cycles. It keeps `out_valid` low and leaves the read bank unchanged, so the next data load still outputs the next committed block.
- R6: A request sampled while `busy_n` is low is stored and started such that `busy_n` is high for exactly one cycle between the two loads.
- R7: Successive data loads read the two banks alternately, so blocks written back to back are output intact and in order.
- R8: A word accepted into a bank whose block has not finished loading sets `overrun`. It stays set until reset, and it stays 0 under correct ping-pong use.
- R9: A request sampled while a load runs and another request is already stored sets `req_lost`, which stays set until reset. The discarded request changes nothing: it starts no load and does not replace the stored one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a block word |
| in_ready | output | 1 | Responder can accept a word |
| in_data | input | DW | Block word |
| load_req | input | 1 | One-cycle load request |
| load_cmd | input | 1 | 1: command-only request, 0: data load |
| busy_n | output | 1 | Low while a load operation runs |
| out_valid | output | 1 | Array word valid |
| out_data | output | DW | Array word |
| overrun | output | 1 | Sticky: write into an unreleased bank |
| req_lost | output | 1 | Sticky: a request found the waiting slot full |

## Verification
A read bank that swaps at the wrong time shows up on the first word of the next data load as another block's data. This happens most visibly after a command-only load, which must not swap the bank. A stored request that is lost or started twice changes the number and length of `busy_n` low periods within one load time. The one-cycle high gap between back-to-back loads exposes off-by-one errors in the sequencer counter. Errors in bank ownership show up only as a wrong `overrun` level. The bench therefore checks that flag both after clean ping-pong traffic and after a deliberate early write.

// File: rtl/blkld_pkg.sv
package blkld_pkg;
  typedef enum logic {
    LOAD_DATA = 1'b0,
    LOAD_CMD  = 1'b1
  } load_kind_e;

  typedef struct packed {
    logic       vld;
    load_kind_e kind;
  } load_req_t;
endpackage

// File: rtl/blkld_banks.sv
module blkld_banks #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] rd_word [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign rd_word[b] = mem[rd_addr];
  end

  assign rd_data = rd_word[rd_bank];
endmodule

// File: rtl/blkld_slot.sv
module blkld_slot
  import blkld_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  load_req_t new_req,
  input  logic      engine_idle,
  output load_req_t launch,
  output logic      new_taken,
  output logic      pend_vld,
  output logic      lost
);
  load_req_t pend;

  // Stored request has priority; a new one then takes the slot.
  always_comb begin
    launch    = '0;
    new_taken = 1'b0;
    if (engine_idle) begin
      launch    = pend.vld ? pend : new_req;
      new_taken = new_req.vld;
    end else begin
      new_taken = new_req.vld && !pend.vld;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      lost <= 1'b0;
    end else if (engine_idle) begin
      pend <= pend.vld ? new_req : '0;
    end else if (new_req.vld) begin
      if (pend.vld) lost <= 1'b1;
      else          pend <= new_req;
    end
  end

  assign pend_vld = pend.vld;
endmodule

// File: rtl/blkld_seq.sv
module blkld_seq
  import blkld_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int LOAD_CYCLES = 8,
  parameter int CMD_CYCLES  = 3,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int MAXC = (LOAD_CYCLES > CMD_CYCLES) ? LOAD_CYCLES : CMD_CYCLES,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  load_req_t     launch,
  output logic          active,
  output logic          rd_bank,
  output logic [AW-1:0] rd_addr,
  output logic          stream_vld,
  output logic          data_done
);
  load_kind_e    kind;
  logic [CW-1:0] cnt;
  logic          last;

  assign last = (kind == LOAD_CMD) ? (cnt == CW'(CMD_CYCLES - 1))
                                   : (cnt == CW'(LOAD_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      kind    <= LOAD_DATA;
      cnt     <= '0;
      rd_bank <= 1'b0;
    end else if (!active) begin
      if (launch.vld) begin
        active <= 1'b1;
        kind   <= launch.kind;
        cnt    <= '0;
      end
    end else if (last) begin
      active <= 1'b0;
      if (kind == LOAD_DATA) rd_bank <= ~rd_bank;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign data_done  = active && last && (kind == LOAD_DATA);
  assign stream_vld = active && (kind == LOAD_DATA) && (cnt < CW'(DEPTH));
  assign rd_addr    = cnt[AW-1:0];
endmodule

// File: rtl/blkld_responder.sv
module blkld_responder
  import blkld_pkg::*;
#(
  parameter int DW          = 8,
  parameter int DEPTH       = 4,
  parameter int LOAD_CYCLES = 8,
  parameter int CMD_CYCLES  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          load_req,
  input  logic          load_cmd,
  output logic          busy_n,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          overrun,
  output logic          req_lost
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  load_req_t     new_req, launch;
  logic          new_taken, pend_vld, active, data_done;
  logic          wbank, rd_bank, wr_fire, commit;
  logic [AW:0]   wcnt;
  logic [1:0]    held, held_nxt;
  logic [AW-1:0] rd_addr;

  assign new_req  = '{vld: load_req, kind: (load_cmd ? LOAD_CMD : LOAD_DATA)};
  assign in_ready = (wcnt < (AW+1)'(DEPTH));
  assign wr_fire  = in_valid && in_ready;
  assign commit   = new_taken && (new_req.kind == LOAD_DATA);
  assign busy_n   = ~active;

  blkld_slot u_slot (
    .clk(clk), .rst_n(rst_n), .new_req(new_req), .engine_idle(~active),
    .launch(launch), .new_taken(new_taken), .pend_vld(pend_vld), .lost(req_lost)
  );

  blkld_seq #(.DEPTH(DEPTH), .LOAD_CYCLES(LOAD_CYCLES), .CMD_CYCLES(CMD_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .active(active), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .stream_vld(out_valid), .data_done(data_done)
  );

  blkld_banks #(.DW(DW), .DEPTH(DEPTH)) u_banks (
    .clk(clk), .wr_en(wr_fire), .wr_bank(wbank), .wr_addr(wcnt[AW-1:0]),
    .wr_data(in_data), .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(out_data)
  );

  // Bank ownership: set at commit, released when its data load ends.
  always_comb begin
    held_nxt = held;
    if (data_done) held_nxt[rd_bank] = 1'b0;
    if (commit)    held_nxt[wbank]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbank   <= 1'b0;
      wcnt    <= '0;
      held    <= '0;
      overrun <= 1'b0;
    end else begin
      held <= held_nxt;
      if (wr_fire && held[wbank]) overrun <= 1'b1;
      if (commit) begin
        wbank <= ~wbank;
        wcnt  <= '0;
      end else if (wr_fire) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/blkld_checker.sv
module blkld_checker #(
  parameter int LOAD_CYCLES = 8,
  parameter int CMD_CYCLES  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic load_req,
  input logic busy_n,
  input logic out_valid,
  input logic in_valid,
  input logic in_ready,
  input logic overrun,
  input logic req_lost,
  input logic pend_vld
);
  int low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)       low_run <= 0;
    else if (!busy_n) low_run <= low_run + 1;
    else              low_run <= 0;
  end

  assert_stream_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !busy_n);

  assert_load_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> (low_run == LOAD_CYCLES || low_run == CMD_CYCLES));

  assert_idle_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && load_req && !pend_vld) |=> !busy_n);

  assert_pend_launch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && pend_vld) |=> !busy_n);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(in_valid && in_ready));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_lost_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_lost |=> req_lost);
endmodule

bind blkld_responder blkld_checker #(.LOAD_CYCLES(LOAD_CYCLES), .CMD_CYCLES(CMD_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_req(load_req), .busy_n(busy_n), .out_valid(out_valid),
  .in_valid(in_valid), .in_ready(in_ready), .overrun(overrun), .req_lost(req_lost),
  .pend_vld(pend_vld)
);

// File: tb/blkld_responder_test.sv
`timescale 1ns/1ps
module blkld_responder_test;
  localparam int DW = 8, DEPTH = 4, LOADC = 8, CMDC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, load_req = 1'b0, load_cmd = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, busy_n, out_valid, overrun, req_lost;
  logic [DW-1:0] out_data;

  always #4 clk = ~clk;

  blkld_responder #(.DW(DW), .DEPTH(DEPTH), .LOAD_CYCLES(LOADC), .CMD_CYCLES(CMDC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .load_req(load_req), .load_cmd(load_cmd), .busy_n(busy_n), .out_valid(out_valid),
    .out_data(out_data), .overrun(overrun), .req_lost(req_lost)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  // Port monitor: busy_n low-run lengths, preceding high gaps, streamed words.
  int nlow = 0, run_lo = 0, run_hi = 0, nword = 0;
  int lows [8];
  int gaps [8];
  logic [DW-1:0] words [16];

  always @(negedge clk) if (rst_n) begin
    if (!busy_n) begin
      if (run_lo == 0 && nlow < 8) gaps[nlow] = run_hi;
      run_lo++;
      run_hi = 0;
    end else begin
      if (run_lo > 0) begin
        if (nlow < 8) lows[nlow] = run_lo;
        nlow++;
        run_lo = 0;
      end
      run_hi++;
    end
    if (out_valid && nword < 16) begin
      words[nword] = out_data;
      nword++;
    end
  end

  typedef struct packed {
    logic          cmd;
    logic [DW-1:0] base;
    logic [7:0]    len;
  } vec_t;

  localparam vec_t VT [6] = '{
    '{1'b0, 8'h10, 8'(LOADC)},
    '{1'b0, 8'h20, 8'(LOADC)},
    '{1'b1, 8'h00, 8'(CMDC)},
    '{1'b0, 8'h30, 8'(LOADC)},
    '{1'b0, 8'hA5, 8'(LOADC)},
    '{1'b1, 8'h00, 8'(CMDC)}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    nlow = 0; run_lo = 0; run_hi = 0; nword = 0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_req(input logic cmd);
    load_req = 1'b1; load_cmd = cmd;
    @(negedge clk);
    load_req = 1'b0; load_cmd = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 3) begin
      @(negedge clk);
      q = busy_n ? q + 1 : 0;
    end
  endtask

  task automatic check_words(input int first, input logic [DW-1:0] base, input string tag);
    for (int w = 0; w < DEPTH; w++)
      check(words[first+w] == 8'(base + w), tag, int'(words[first+w]), int'(8'(base + w)));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy_n == 1'b1,    "R1 busy_n",    busy_n, 1);
    check(in_ready == 1'b1,  "R1 in_ready",  in_ready, 1);
    check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    check(overrun == 1'b0,   "R1 overrun",   overrun, 0);
    check(req_lost == 1'b0,  "R1 req_lost",  req_lost, 0);

    // Vector table: R3 data length, R4 stream, R5 command length, R7 alternation
    for (int i = 0; i < 6; i++) begin
      clear_mon();
      if (!VT[i].cmd) for (int w = 0; w < DEPTH; w++) push(8'(VT[i].base + w));
      pulse_req(VT[i].cmd);
      wait_idle();
      check(nlow == 1, "R3/R5 one busy period", nlow, 1);
      check(lows[0] == int'(VT[i].len), "R3/R5 busy length", lows[0], int'(VT[i].len));
      check(nword == (VT[i].cmd ? 0 : DEPTH), "R4/R5 word count", nword, VT[i].cmd ? 0 : DEPTH);
      if (!VT[i].cmd) check_words(0, VT[i].base, "R4/R7 stream data");
    end

    // R2 back-pressure
    clear_mon();
    for (int w = 0; w < DEPTH; w++) push(8'(8'h40 + w));
    check(in_ready == 1'b0, "R2 ready low when full", in_ready, 0);
    push(8'hEE);
    pulse_req(1'b0);
    check(in_ready == 1'b1, "R2 ready back after request", in_ready, 1);
    wait_idle();
    check(nword == DEPTH, "R2 word count", nword, DEPTH);
    check_words(0, 8'h40, "R2 refused word not stored");

    // R6 stored request, R7 ping-pong, R8 clean use
    clear_mon();
    for (int w = 0; w < DEPTH; w++) push(8'(8'h50 + w));
    pulse_req(1'b0);
    for (int w = 0; w < DEPTH; w++) push(8'(8'h60 + w));
    pulse_req(1'b0);
    wait_idle();
    check(nlow == 2, "R6 two loads", nlow, 2);
    check(lows[0] == LOADC && lows[1] == LOADC, "R6 lengths", lows[1], LOADC);
    check(gaps[1] == 1, "R6 one-cycle gap", gaps[1], 1);
    check_words(0, 8'h50, "R7 first block");
    check_words(DEPTH, 8'h60, "R7 second block");
    check(overrun == 1'b0, "R8 no overrun on clean use", overrun, 0);

    // R9 dropped request, R8 early write
    clear_mon();
    for (int w = 0; w < DEPTH; w++) push(8'(8'h70 + w));
    pulse_req(1'b0);
    for (int w = 0; w < DEPTH; w++) push(8'(8'h80 + w));
    pulse_req(1'b0);
    check(req_lost == 1'b0, "R9 single stored ok", req_lost, 0);
    pulse_req(1'b1);
    check(req_lost == 1'b1, "R9 lost flag", req_lost, 1);
    push(8'h99);
    check(overrun == 1'b1, "R8 overrun flag", overrun, 1);
    wait_idle();
    check(nlow == 2, "R9 dropped request starts nothing", nlow, 2);
    check(lows[1] == LOADC, "R9 stored request kept", lows[1], LOADC);
    check_words(DEPTH, 8'h80, "R9 stored block output");
    check(overrun == 1'b1 && req_lost == 1'b1, "R8/R9 sticky", overrun, 1);

    // R1 flags cleared by reset
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(overrun == 1'b0,  "R1 overrun cleared", overrun, 0);
    check(req_lost == 1'b0, "R1 req_lost cleared", req_lost, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

    summary();
  end
endmodule